// File: doc/BRIEF.md
# Programmable Interval Timer Channel (Rate and Square-Wave Modes)

This block is a single down-counting channel of an interval timer. A slow count-enable strobe (`tick`), one clock cycle wide, paces all counting; between strobes nothing moves. Software programs the channel through a write strobe that carries a 16-bit initial count and a one-bit mode. The channel can act as a rate generator, which gives one short low pulse per period, or as a square-wave generator, which gives a 50 % duty output with the high half one tick longer when the count is odd.

A written count is not used on the write cycle. The first `tick` strictly after the write loads it. Once the channel is running, a new write is held back until the current reload boundary arrives, so the half-cycle or period in progress finishes with its old length. Each load or reload gives a one-cycle `reload_pulse`. The write port is a plain register strobe and not a stream: every write is accepted in the cycle it is presented, and a later write replaces one that is still waiting.

Top module: `pit_channel`

## Requirements
- R1: A count written in cycle c is loaded on the first tick in a cycle after c; a tick in cycle c itself does not load it. Before its first load the channel does not count.
- R2: In square-wave mode (wr_mode=1) the sum of the high and low half-cycles, in ticks, equals the programmed count.
- R3: In square-wave mode, out is high from the first load, and the internal count drops by two on each tick, so it stays even.
- R4: In square-wave mode, out changes level at every half-cycle reload, so high and low half-cycles alternate.
- R5: In rate mode (wr_mode=0) a reload happens every N ticks, where N is the programmed count.
- R6: In rate mode with N of 2 or more, out is high except for exactly one tick-interval, which is the one that ends in the reload.
- R7: A programmed count of 0 acts as 65536.
- R8: In square-wave mode with an odd count N, the high half lasts (N+1)/2 ticks and the low half lasts (N-1)/2 ticks.
- R9: A write made while the channel is running does not change the half-cycle or period in progress. It takes effect at the next reload boundary.
- R10: reload_pulse is high for one clock cycle after each tick that loads or reloads the count, and at no other time.
- R11: In a cycle without tick, neither out nor reload_pulse changes.
- R12: The mode is captured together with the count and becomes active when that count is loaded.
- R13: After reset, out is high and reload_pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable strobe, one cycle wide |
| wr_en | input | 1 | Write strobe for count and mode |
| wr_data | input | 16 | Initial count (0 means 65536) |
| wr_mode | input | 1 | 0 = rate generator, 1 = square wave |
| out | output | 1 | Channel output |
| reload_pulse | output | 1 | One-cycle strobe after each load or reload |

## Verification
The bench checks the load delay by writing in the same cycle as a tick. A design that loaded on the write would give its first reload one tick early. It programs odd counts and checks both half-cycle lengths, which catches a design that rounds the halves the wrong way or lets the period drift by one. It writes new counts in the middle of a half-cycle and in the middle of a rate period, including a switch of mode, and expects the old interval to finish first. A design that applied the write immediately would cut that interval short. A count of zero must produce a 32768-tick high half, which catches a channel that stops or wraps at zero. Idle cycles are inserted at random between ticks, and any change on out or reload_pulse during them is reported.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic {
    PIT_RATE   = 1'b0,
    PIT_SQUARE = 1'b1
  } pit_mode_e;
endpackage

// File: rtl/pit_cfg_hold.sv
// Holds the count/mode written by software and the set that is in use.
module pit_cfg_hold
  import pit_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  pit_mode_e     wr_mode,
  input  logic          take,
  output logic          pend,
  output logic [CW-1:0] use_val,
  output pit_mode_e     use_mode
);
  logic [CW-1:0] nxt_val, act_val;
  pit_mode_e     nxt_mode, act_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_val  <= '0;
      act_val  <= '0;
      nxt_mode <= PIT_RATE;
      act_mode <= PIT_RATE;
      pend     <= 1'b0;
    end else begin
      if (take && pend) begin
        act_val  <= nxt_val;
        act_mode <= nxt_mode;
      end
      if (wr_en) begin
        nxt_val  <= wr_data;
        nxt_mode <= wr_mode;
      end
      pend <= wr_en ? 1'b1 : (take ? 1'b0 : pend);
    end
  end

  // A waiting write wins over the set in use at the next boundary
  assign use_val  = pend ? nxt_val  : act_val;
  assign use_mode = pend ? nxt_mode : act_mode;
endmodule

// File: rtl/pit_reload_calc.sv
// Computes the value and output level to apply at a load or reload.
module pit_reload_calc
  import pit_pkg::*;
#(
  parameter int CW = 16,
  localparam int CNTW = CW + 1
) (
  input  logic [CW-1:0]   val,
  input  pit_mode_e       mode,
  input  logic            out_now,
  output logic [CNTW-1:0] rl_cnt,
  output logic            rl_out
);
  logic [CNTW-1:0] full, hi_span, lo_span;
  logic            go_low;

  always_comb begin
    full    = (val == '0) ? (CNTW'(1) << CW) : {1'b0, val};
    hi_span = full + CNTW'(full[0]);
    lo_span = full - CNTW'(full[0]);
    go_low  = out_now && (lo_span != '0);
    if (mode == PIT_RATE) begin
      rl_cnt = full;
      rl_out = 1'b1;
    end else begin
      rl_cnt = go_low ? lo_span : hi_span;
      rl_out = !go_low;
    end
  end
endmodule

// File: rtl/pit_count_core.sv
// The down counter, output level and reload strobe.
module pit_count_core
  import pit_pkg::*;
#(
  parameter int CW = 16,
  localparam int CNTW = CW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            pend,
  input  pit_mode_e       use_mode,
  input  logic [CNTW-1:0] rl_cnt,
  input  logic            rl_out,
  output logic            take,
  output logic            armed,
  output logic            out_q,
  output logic            pulse_q
);
  logic [CNTW-1:0] cnt;
  pit_mode_e       run_mode;
  logic            hit;

  assign hit  = (run_mode == PIT_RATE) ? (cnt == CNTW'(1)) : (cnt == CNTW'(2));
  assign take = tick && (armed ? hit : pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      run_mode <= PIT_RATE;
      armed    <= 1'b0;
      out_q    <= 1'b1;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= take;
      if (take) begin
        cnt      <= rl_cnt;
        out_q    <= rl_out;
        run_mode <= use_mode;
        armed    <= 1'b1;
      end else if (tick && armed) begin
        if (run_mode == PIT_RATE) begin
          cnt   <= cnt - CNTW'(1);
          out_q <= (cnt != CNTW'(2));
        end else begin
          cnt <= cnt - CNTW'(2);
        end
      end
    end
  end

  AST_SQUARE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && run_mode == PIT_SQUARE) |-> !cnt[0]); // R3
  AST_RATE_LOW_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && armed && run_mode == PIT_RATE && !out_q) |=> out_q); // R6
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CW = 16,
  localparam int CNTW = CW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic          wr_mode,
  output logic          out,
  output logic          reload_pulse
);
  logic            take, pend, armed, out_q, pulse_q, rl_out;
  logic [CW-1:0]   use_val;
  pit_mode_e       use_mode;
  logic [CNTW-1:0] rl_cnt;

  pit_cfg_hold #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mode(pit_mode_e'(wr_mode)), .take(take), .pend(pend),
    .use_val(use_val), .use_mode(use_mode)
  );

  pit_reload_calc #(.CW(CW)) u_calc (
    .val(use_val), .mode(use_mode), .out_now(armed && out_q),
    .rl_cnt(rl_cnt), .rl_out(rl_out)
  );

  pit_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pend(pend), .use_mode(use_mode),
    .rl_cnt(rl_cnt), .rl_out(rl_out), .take(take), .armed(armed),
    .out_q(out_q), .pulse_q(pulse_q)
  );

  assign out          = out_q;
  assign reload_pulse = pulse_q;

  AST_PULSE_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    reload_pulse |-> $past(tick)); // R10
  AST_QUIET_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(out) && !reload_pulse)); // R11
  AST_NO_LOAD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pend && !armed) |=> !reload_pulse); // R1
endmodule

// File: tb/tb_pit_channel.sv
module tb_pit_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, wr_mode = 1'b0;
  logic [15:0] wr_data = '0;
  logic        out, reload_pulse;
  logic        out_s, pulse_s;
  int          total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pit_channel dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mode(wr_mode), .out(out), .reload_pulse(reload_pulse)
  );

  function automatic int full_of(int n);
    return (n == 0) ? 65536 : n;
  endfunction
  function automatic int hi_of(int n);
    return (full_of(n) + 1) / 2;
  endfunction
  function automatic int lo_of(int n);
    return full_of(n) / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit tk, input bit we, input int d, input bit m);
    tick = tk; wr_en = we; wr_data = 16'(d); wr_mode = m;
    @(posedge clk); #1;
    out_s = out; pulse_s = reload_pulse;
    tick = 1'b0; wr_en = 1'b0;
  endtask

  task automatic idle_step();
    logic o_prev;
    o_prev = out_s;
    step(1'b0, 1'b0, 0, 1'b0);
    check(!pulse_s && out_s == o_prev, "R11 R10 quiet without tick", int'({pulse_s, out_s}), int'({1'b0, o_prev}));
  endtask

  task automatic until_pulse(input int maxt, input bit idles, output int nt, output int lows, output int last_low);
    nt = 0; lows = 0; last_low = -1;
    while (1) begin
      if (idles && ($urandom % 3 == 0)) idle_step();
      step(1'b1, 1'b0, 0, 1'b0);
      nt++;
      if (pulse_s) break;
      if (!out_s) begin lows++; last_low = nt; end
      if (nt >= maxt) break;
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic run_square(input int n);
    int nt, lw, ll, th;
    bit idl;
    idl = (full_of(n) < 1000);
    do_reset();
    step(1'b1, 1'b1, n, 1'b1);
    check(!pulse_s, "R1 no load on write tick", pulse_s, 0);
    until_pulse(5, idl, nt, lw, ll);
    check(nt == 1, "R1 load on next tick", nt, 1);
    check(out_s == 1'b1, "R3 starts high", out_s, 1);
    until_pulse(hi_of(n) + 2, idl, nt, lw, ll);
    th = nt;
    check(nt == hi_of(n), "R8 R7 high half length", nt, hi_of(n));
    if (lo_of(n) > 0) begin
      check(out_s == 1'b0, "R4 flips low", out_s, 0);
      until_pulse(lo_of(n) + 2, idl, nt, lw, ll);
      check(nt == lo_of(n), "R8 low half length", nt, lo_of(n));
      check(out_s == 1'b1, "R4 flips high", out_s, 1);
      check(th + nt == full_of(n), "R2 period", th + nt, full_of(n));
    end
  endtask

  task automatic run_rate(input int n);
    int nt, lw, ll;
    do_reset();
    step(1'b0, 1'b1, n, 1'b0);
    until_pulse(5, 1'b1, nt, lw, ll);
    check(nt == 1, "R1 load on first later tick", nt, 1);
    check(out_s == 1'b1, "R12 rate mode starts high", out_s, 1);
    repeat (2) begin
      until_pulse(full_of(n) + 2, 1'b1, nt, lw, ll);
      check(nt == full_of(n), "R5 rate period", nt, full_of(n));
      check(lw == 1 && ll == full_of(n) - 1, "R6 single low tick", lw * 1000 + ll, 1000 + full_of(n) - 1);
      check(out_s == 1'b1, "R6 high after reload", out_s, 1);
    end
  endtask

  initial begin
    int nt, lw, ll;
    void'($urandom(32'd1234));
    // R13 reset state
    do_reset();
    check(out_s == 1'b1 && !pulse_s, "R13 reset state", int'({out_s, pulse_s}), 2);
    repeat (4) step(1'b1, 1'b0, 0, 1'b0);
    check(!pulse_s && out_s, "R1 no counting before write", int'({out_s, pulse_s}), 2);

    run_square(10);
    run_square(7);
    run_square(1);
    run_rate(2);
    run_rate(5);

    // R9 pending write inside a square half-cycle
    do_reset();
    step(1'b1, 1'b1, 10, 1'b1);
    until_pulse(5, 1'b0, nt, lw, ll);
    step(1'b1, 1'b0, 0, 1'b0);
    step(1'b1, 1'b0, 0, 1'b0);
    step(1'b0, 1'b1, 6, 1'b1);
    until_pulse(10, 1'b1, nt, lw, ll);
    check(nt == 3 && out_s == 1'b0, "R9 old half finishes", nt, 3);
    until_pulse(10, 1'b1, nt, lw, ll);
    check(nt == 3 && out_s == 1'b1, "R9 new low half", nt, 3);
    until_pulse(10, 1'b1, nt, lw, ll);
    check(nt == 3 && out_s == 1'b0, "R9 new high half", nt, 3);

    // R12 mode switch waits for rate-period boundary
    do_reset();
    step(1'b1, 1'b1, 4, 1'b0);
    until_pulse(5, 1'b0, nt, lw, ll);
    step(1'b1, 1'b0, 0, 1'b0);
    step(1'b0, 1'b1, 6, 1'b1);
    until_pulse(10, 1'b1, nt, lw, ll);
    check(nt == 3 && out_s == 1'b1, "R12 switch at boundary", nt, 3);
    until_pulse(10, 1'b1, nt, lw, ll);
    check(nt == 3 && out_s == 1'b0, "R12 square after switch", nt, 3);

    // random counts and modes
    for (int i = 0; i < 10; i++) begin
      int n;
      n = 2 + int'($urandom % 39);
      if ($urandom % 2 == 0) run_rate(n); else run_square(n);
    end

    // R7 zero count acts as 65536
    run_square(0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(150000 * 5);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule